// File: doc/BRIEF.md
# Keyed-Unlock Watchdog Timer

This block is a watchdog timer for a chip-level register bus. Software sees three 32-bit registers: a control/status word, the live counter, and the timeout value. The counter advances on a slow tick strobe, either once per strobe or once per 256 strobes when the divider is on. When the count meets the timeout value, the block sets a sticky timeout flag and issues a one-cycle reset request. Software prevents that by writing a refresh key to the counter register.

The configuration is protected. It can be changed only inside a short window opened by an unlock key written to the counter register. That key is either one 32-bit word or two 16-bit halves in a fixed order; a control bit selects which form applies. A new configuration is staged and applied a few cycles later, and a status bit reports whether it has been applied. Software can seal the configuration for good by writing it with the update-allowed bit clear.

Top module: `wdt_keyguard`

## Requirements
- R1: After reset the control/status word reads 0x5A0, which means enable (bit 7), update-allowed (bit 5), clock select 01 (bits 9:8) and reconfiguration-complete (bit 10). The timeout register reads 0xFFFF, the counter reads 0 and `rst_req` is low.
- R2: While enabled and not frozen, the counter at offset 0x4 advances by one on each `slow_tick` when the prescaler (bit 12) is clear.
- R3: With the prescaler bit set, the counter advances once every 256 `slow_tick` strobes.
- R4: Writing exactly 0xB480A602 to offset 0x4 returns the counter and the prescaler phase to zero. Any other value leaves the count alone.
- R5: With 32-bit command mode set (bit 13), one write of 0xD928C520 to offset 0x4 unlocks the block, and the unlocked bit (bit 11) reads 1. A lone 0xC520 does not unlock it.
- R6: With bit 13 clear, unlocking needs two consecutive counter writes, 0x0000C520 and then 0x0000D928. The reverse order, a wrong second half, an intervening write, or the 32-bit key all leave the block locked.
- R7: While the block is locked, writes to offset 0x0 (except the flag clear) and to offset 0x8 are ignored.
- R8: The unlock window closes after WIN (256) clock cycles or after the first accepted configuration write, whichever comes first. Later configuration writes are then ignored.
- R9: After an accepted configuration write, bit 10 reads 0 and the old values stay visible. SYNC_LAT (3) cycles later the new values take effect and bit 10 reads 1.
- R10: When the block is running and the counter equals the timeout value, the next cycle sets the flag (bit 14), raises `rst_req` for exactly one cycle and restarts the count at 0.
- R11: Writing 1 to bit 14 at offset 0x0 clears the flag, whether or not the block is unlocked, and changes no other field.
- R12: A control/status write that is accepted with bit 5 clear seals the block. Every later unlock key is ignored until reset.
- R13: With enable (bit 7) clear, the counter holds at 0 and no reset request is issued.
- R14: While `lp_wait` is high and bit 1 is clear, or `lp_stop` is high and bit 0 is clear, the counter is frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One-cycle strobe from the slow time base |
| lp_wait | input | 1 | System is in the wait low-power state |
| lp_stop | input | 1 | System is in the stop low-power state |
| bus_addr | input | ADDR_W (4) | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
The hardest state to reach is a sealed block. Reaching it takes an accepted unlock in the correct key mode, a control write with update-allowed clear, and a wait for the staged value to apply. Only after that can a later, correctly formed key be shown to have no effect. The bench reaches it at the very end of the run, after it has switched the key mode from 16-bit to 32-bit through the unlock path itself. It then confirms through readback that the unlocked bit stays low and that a timeout write is dropped. Expiry is aimed at exactly, by counting tick strobes up to the timeout value.

// File: rtl/wdt_keyguard_pkg.sv
package wdt_keyguard_pkg;

  // Register byte offsets (software decodes these)
  localparam int OFF_CS  = 'h0;
  localparam int OFF_CNT = 'h4;
  localparam int OFF_TOV = 'h8;

  // Control/status bit positions
  localparam int B_FLAG  = 14;
  localparam int B_CMD32 = 13;
  localparam int B_PRESC = 12;
  localparam int B_UNLK  = 11;
  localparam int B_RCS   = 10;
  localparam int B_CLKHI = 9;
  localparam int B_CLKLO = 8;
  localparam int B_EN    = 7;
  localparam int B_UPD   = 5;
  localparam int B_RWAIT = 1;
  localparam int B_RSTOP = 0;

  // Magic keys written to the counter register
  localparam logic [31:0] KEY_REFRESH = 32'hB480_A602;
  localparam logic [31:0] KEY_UNLOCK  = 32'hD928_C520;
  localparam logic [31:0] KEY_HALF_LO = 32'h0000_C520;
  localparam logic [31:0] KEY_HALF_HI = 32'h0000_D928;

  typedef struct packed {
    logic       cmd32;
    logic       presc;
    logic [1:0] clksel;
    logic       en;
    logic       upd;
    logic       run_wait;
    logic       run_stop;
  } cfg_t;

  localparam cfg_t CFG_RST = '{cmd32: 1'b0, presc: 1'b0, clksel: 2'b01,
                               en: 1'b1, upd: 1'b1, run_wait: 1'b0,
                               run_stop: 1'b0};

  function automatic cfg_t word_to_cfg(input logic [31:0] w);
    cfg_t c;
    c.cmd32    = w[B_CMD32];
    c.presc    = w[B_PRESC];
    c.clksel   = w[B_CLKHI:B_CLKLO];
    c.en       = w[B_EN];
    c.upd      = w[B_UPD];
    c.run_wait = w[B_RWAIT];
    c.run_stop = w[B_RSTOP];
    return c;
  endfunction

  function automatic logic [31:0] cfg_to_word(input cfg_t c, input logic flag,
                                              input logic unlk, input logic rcs);
    logic [31:0] w;
    w = '0;
    w[B_FLAG]          = flag;
    w[B_CMD32]         = c.cmd32;
    w[B_PRESC]         = c.presc;
    w[B_UNLK]          = unlk;
    w[B_RCS]           = rcs;
    w[B_CLKHI:B_CLKLO] = c.clksel;
    w[B_EN]            = c.en;
    w[B_UPD]           = c.upd;
    w[B_RWAIT]         = c.run_wait;
    w[B_RSTOP]         = c.run_stop;
    return w;
  endfunction

  // Counter is allowed to move this cycle
  function automatic logic run_allowed(input cfg_t c, input logic in_wait,
                                       input logic in_stop);
    return c.en && !(in_wait && !c.run_wait) && !(in_stop && !c.run_stop);
  endfunction

endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock
  import wdt_keyguard_pkg::*;
#(
  parameter int WIN = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cnt_wr,
  input  logic [31:0] wdata,
  input  logic        cmd32,
  input  logic        cfg_acc,
  input  logic        seal_set,
  output logic        unlocked,
  output logic        sealed,
  output logic        key_ok
);
  localparam int WIN_W = $clog2(WIN + 1);

  logic             half_q;
  logic [WIN_W-1:0] win_q;
  logic             unl_q;
  logic             seal_q;
  logic             key32, key16;

  assign key32  = cnt_wr && cmd32 && (wdata == KEY_UNLOCK);
  assign key16  = cnt_wr && !cmd32 && half_q && (wdata == KEY_HALF_HI);
  assign key_ok = (key32 || key16) && !seal_q;

  // First half of the 16-bit sequence, cleared by any other counter write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      half_q <= 1'b0;
    else if (cnt_wr) half_q <= !cmd32 && (wdata == KEY_HALF_LO);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unl_q <= 1'b0;
      win_q <= '0;
    end else if (unl_q && cfg_acc) begin
      unl_q <= 1'b0;
      win_q <= '0;
    end else if (key_ok) begin
      unl_q <= 1'b1;
      win_q <= WIN_W'(WIN);
    end else if (unl_q) begin
      if (win_q == WIN_W'(1)) unl_q <= 1'b0;
      win_q <= win_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seal_q <= 1'b0;
    else if (seal_set) seal_q <= 1'b1;
  end

  assign unlocked = unl_q;
  assign sealed   = seal_q;

endmodule

// File: rtl/wdt_cfg_sync.sv
module wdt_cfg_sync
  import wdt_keyguard_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int SYNC_LAT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_acc,
  input  logic             tov_acc,
  input  cfg_t             cfg_in,
  input  logic [CNT_W-1:0] tov_in,
  output cfg_t             cfg,
  output logic [CNT_W-1:0] toval,
  output logic             rcs
);
  localparam int PEND_W = $clog2(SYNC_LAT + 1);

  cfg_t              shd_cfg, cfg_q;
  logic [CNT_W-1:0]  shd_tov, tov_q;
  logic [PEND_W-1:0] pend_q;
  logic              apply;

  assign apply = (pend_q == PEND_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_cfg <= CFG_RST;
      shd_tov <= '1;
    end else begin
      if (cs_acc)  shd_cfg <= cfg_in;
      if (tov_acc) shd_tov <= tov_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pend_q <= '0;
    else if (cs_acc || tov_acc) pend_q <= PEND_W'(SYNC_LAT);
    else if (pend_q != '0)      pend_q <= pend_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RST;
      tov_q <= '1;
    end else if (apply) begin
      cfg_q <= shd_cfg;
      tov_q <= shd_tov;
    end
  end

  assign cfg   = cfg_q;
  assign toval = tov_q;
  assign rcs   = (pend_q == '0);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W    = 16,
  parameter int PRESCALE = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             run,
  input  logic             presc,
  input  logic             tick,
  input  logic             refresh,
  input  logic             hold,
  input  logic [CNT_W-1:0] toval,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  localparam int PRE_W = $clog2(PRESCALE);

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             adv;

  assign adv    = run && tick && (!presc || pre_q == PRE_W'(PRESCALE - 1));
  assign expire = run && !hold && (cnt_q == toval);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pre_q <= '0;
    else if (!en || refresh)     pre_q <= '0;
    else if (run && tick && presc) pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (!en || expire || refresh)   cnt_q <= '0;
    else if (adv)                        cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/wdt_keyguard.sv
module wdt_keyguard
  import wdt_keyguard_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CNT_W    = 16,
  parameter int WIN      = 256,
  parameter int SYNC_LAT = 3,
  parameter int PRESCALE = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              lp_wait,
  input  logic              lp_stop,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              rst_req
);
  logic             cs_wr, cnt_wr, tov_wr;
  logic             cs_acc, tov_acc, cfg_acc, seal_set, refresh;
  logic             unlocked, sealed, key_ok;
  cfg_t             cfg;
  logic [CNT_W-1:0] toval, cnt;
  logic             rcs, run, expire;
  logic             flag_q, rst_req_q;

  assign cs_wr  = bus_we && (bus_addr == ADDR_W'(OFF_CS));
  assign cnt_wr = bus_we && (bus_addr == ADDR_W'(OFF_CNT));
  assign tov_wr = bus_we && (bus_addr == ADDR_W'(OFF_TOV));

  assign cs_acc   = cs_wr && unlocked;
  assign tov_acc  = tov_wr && unlocked;
  assign cfg_acc  = cs_acc || tov_acc;
  assign seal_set = cs_acc && !bus_wdata[B_UPD];
  assign refresh  = cnt_wr && (bus_wdata == KEY_REFRESH);
  assign run      = run_allowed(cfg, lp_wait, lp_stop);

  wdt_unlock #(.WIN(WIN)) u_unlock (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_wr   (cnt_wr),
    .wdata    (bus_wdata),
    .cmd32    (cfg.cmd32),
    .cfg_acc  (cfg_acc),
    .seal_set (seal_set),
    .unlocked (unlocked),
    .sealed   (sealed),
    .key_ok   (key_ok)
  );

  wdt_cfg_sync #(.CNT_W(CNT_W), .SYNC_LAT(SYNC_LAT)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_acc  (cs_acc),
    .tov_acc (tov_acc),
    .cfg_in  (word_to_cfg(bus_wdata)),
    .tov_in  (bus_wdata[CNT_W-1:0]),
    .cfg     (cfg),
    .toval   (toval),
    .rcs     (rcs)
  );

  wdt_counter #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cfg.en),
    .run     (run),
    .presc   (cfg.presc),
    .tick    (slow_tick),
    .refresh (refresh),
    .hold    (rst_req_q),
    .toval   (toval),
    .cnt     (cnt),
    .expire  (expire)
  );

  // Sticky timeout flag: set wins over a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q    <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= expire;
      if (expire)                         flag_q <= 1'b1;
      else if (cs_wr && bus_wdata[B_FLAG]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFF_CS))
      bus_rdata = cfg_to_word(cfg, flag_q, unlocked, rcs);
    else if (bus_addr == ADDR_W'(OFF_CNT))
      bus_rdata = 32'(cnt);
    else if (bus_addr == ADDR_W'(OFF_TOV))
      bus_rdata = 32'(toval);
  end

  assign rst_req = rst_req_q;

endmodule

// File: rtl/wdt_keyguard_chk.sv
module wdt_keyguard_chk #(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              unlocked,
  input logic              sealed,
  input logic              cfg_acc,
  input logic              rcs,
  input logic              rst_req,
  input logic              flag,
  input logic              en,
  input logic [CNT_W-1:0]  cnt
);
  // R10: reset request lasts a single cycle
  assert_req_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R10: a reset request is always accompanied by the flag
  assert_req_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> flag);

  // R5: the unlocked state only opens after a counter-register write
  assert_unlock_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(bus_we && bus_addr == ADDR_W'(4)));

  // R9: an accepted configuration write makes the update pending
  assert_rcs_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_acc |=> !rcs);

  // R12: a sealed block never shows unlocked
  assert_sealed_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sealed |-> !unlocked);

  // R2: the count only steps up by one or restarts at zero
  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1 || cnt == '0));

  // R13: a disabled counter stays at zero
  assert_disabled_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && $past(!en)) |-> cnt == '0);

endmodule

bind wdt_keyguard wdt_keyguard_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .unlocked (unlocked),
  .sealed   (sealed),
  .cfg_acc  (cfg_acc),
  .rcs      (rcs),
  .rst_req  (rst_req),
  .flag     (flag_q),
  .en       (cfg.en),
  .cnt      (cnt)
);

// File: tb/tb_wdt_keyguard.sv
`timescale 1ns/100ps
module tb_wdt_keyguard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic        lp_wait = 1'b0;
  logic        lp_stop = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wdt_keyguard dut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .lp_wait(lp_wait),
    .lp_stop(lp_stop), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  always @(posedge clk) if (rst_req) pulses++;

  // op: 0 write, 1 read and compare, 2 idle <data> cycles
  localparam int NV = 38;
  localparam logic [77:0] VEC [NV] = '{
    {2'd1, 4'h0, 32'h0,         32'h0000_05A0, 8'd1},  // R1 control word
    {2'd1, 4'h8, 32'h0,         32'h0000_FFFF, 8'd1},  // R1 timeout
    {2'd1, 4'h4, 32'h0,         32'h0,         8'd1},  // R1 counter
    {2'd0, 4'h8, 32'h1234,      32'h0,         8'd7},  // R7 locked write
    {2'd2, 4'h0, 32'd5,         32'h0,         8'd7},
    {2'd1, 4'h8, 32'h0,         32'h0000_FFFF, 8'd7},
    {2'd1, 4'h0, 32'h0,         32'h0000_05A0, 8'd7},
    {2'd0, 4'h4, 32'hD928_C520, 32'h0,         8'd6},  // R6 word key in 16-bit mode
    {2'd1, 4'h0, 32'h0,         32'h0000_05A0, 8'd6},
    {2'd0, 4'h4, 32'h0000_C520, 32'h0,         8'd6},
    {2'd0, 4'h4, 32'h0000_D928, 32'h0,         8'd6},
    {2'd1, 4'h0, 32'h0,         32'h0000_0DA0, 8'd6},  // R6 unlocked
    {2'd0, 4'h8, 32'h40,        32'h0,         8'd9},
    {2'd1, 4'h0, 32'h0,         32'h0000_01A0, 8'd9},  // R9 pending, R8 closed
    {2'd2, 4'h0, 32'd5,         32'h0,         8'd9},
    {2'd1, 4'h8, 32'h0,         32'h0000_0040, 8'd9},
    {2'd1, 4'h0, 32'h0,         32'h0000_05A0, 8'd9},
    {2'd0, 4'h4, 32'h0000_D928, 32'h0,         8'd6},  // R6 reverse order
    {2'd0, 4'h4, 32'h0000_C520, 32'h0,         8'd6},
    {2'd0, 4'h4, 32'h0000_0001, 32'h0,         8'd6},
    {2'd1, 4'h0, 32'h0,         32'h0000_05A0, 8'd6},
    {2'd0, 4'h4, 32'h0000_C520, 32'h0,         8'd6},  // R6 wrong second half
    {2'd0, 4'h4, 32'h0000_D929, 32'h0,         8'd6},
    {2'd1, 4'h0, 32'h0,         32'h0000_05A0, 8'd6},
    {2'd0, 4'h4, 32'h0000_C520, 32'h0,         8'd5},
    {2'd0, 4'h4, 32'h0000_D928, 32'h0,         8'd5},
    {2'd0, 4'h0, 32'h0000_21A0, 32'h0,         8'd5},  // switch to 32-bit keys
    {2'd2, 4'h0, 32'd5,         32'h0,         8'd5},
    {2'd1, 4'h0, 32'h0,         32'h0000_25A0, 8'd5},
    {2'd0, 4'h4, 32'h0000_C520, 32'h0,         8'd5},  // R5 half key ignored
    {2'd1, 4'h0, 32'h0,         32'h0000_25A0, 8'd5},
    {2'd0, 4'h4, 32'hD928_C520, 32'h0,         8'd5},  // R5 word key
    {2'd1, 4'h0, 32'h0,         32'h0000_2DA0, 8'd5},
    {2'd0, 4'h8, 32'h30,        32'h0,         8'd8},  // R8 first write wins
    {2'd0, 4'h8, 32'h50,        32'h0,         8'd8},
    {2'd2, 4'h0, 32'd5,         32'h0,         8'd8},
    {2'd1, 4'h8, 32'h0,         32'h0000_0030, 8'd8},
    {2'd1, 4'h0, 32'h0,         32'h0000_25A0, 8'd8}
  };

  task automatic chk(input int r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_we = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    slow_tick = 1'b1;
    repeat (n) @(negedge clk);
    slow_tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(1, {31'd0, rst_req}, 32'd0);  // R1

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][77:76])
        2'd0: wr(VEC[i][75:72], VEC[i][71:40]);
        2'd1: begin
          rd(VEC[i][75:72], v);
          chk(int'(VEC[i][7:0]), v, VEC[i][39:8]);
        end
        default: idle(int'(VEC[i][71:40]));
      endcase
    end

    // R8: window expires after WIN cycles
    wr(4'h4, 32'hD928_C520);
    rd(4'h0, v); chk(8, v, 32'h0000_2DA0);
    idle(258);
    rd(4'h0, v); chk(8, v, 32'h0000_25A0);
    wr(4'h8, 32'h77);
    idle(5);
    rd(4'h8, v); chk(8, v, 32'h30);

    // R2: one count per tick
    wr(4'h4, 32'hB480_A602);
    ticks(10);
    rd(4'h4, v); chk(2, v, 32'd10);

    // R4: near-miss key ignored, real key clears
    wr(4'h4, 32'hB480_A603);
    rd(4'h4, v); chk(4, v, 32'd10);
    wr(4'h4, 32'hB480_A602);
    rd(4'h4, v); chk(4, v, 32'd0);

    // R14: low-power freeze
    lp_wait = 1'b1;
    ticks(5);
    rd(4'h4, v); chk(14, v, 32'd0);
    lp_wait = 1'b0;
    ticks(5);
    rd(4'h4, v); chk(14, v, 32'd5);
    lp_stop = 1'b1;
    ticks(3);
    rd(4'h4, v); chk(14, v, 32'd5);
    lp_stop = 1'b0;

    // R10: expiry at count == timeout (0x30)
    wr(4'h4, 32'hB480_A602);
    ticks(48);
    rd(4'h4, v); chk(10, v, 32'd48);
    chk(10, {31'd0, rst_req}, 32'd0);
    @(negedge clk);
    chk(10, {31'd0, rst_req}, 32'd1);
    rd(4'h0, v); chk(10, v, 32'h0000_65A0);
    rd(4'h4, v); chk(10, v, 32'd0);
    @(negedge clk);
    chk(10, {31'd0, rst_req}, 32'd0);
    chk(10, pulses, 32'd1);

    // R11: flag clear while locked
    wr(4'h0, 32'h0000_4000);
    rd(4'h0, v); chk(11, v, 32'h0000_25A0);

    // R3: prescaler
    wr(4'h4, 32'hD928_C520);
    wr(4'h0, 32'h0000_35A0);
    idle(5);
    rd(4'h0, v); chk(3, v, 32'h0000_35A0);
    wr(4'h4, 32'hB480_A602);
    ticks(255);
    rd(4'h4, v); chk(3, v, 32'd0);
    ticks(1);
    rd(4'h4, v); chk(3, v, 32'd1);

    // R13: disabled counter
    wr(4'h4, 32'hD928_C520);
    wr(4'h0, 32'h0000_2120);
    idle(5);
    ticks(60);
    rd(4'h4, v); chk(13, v, 32'd0);
    chk(13, pulses, 32'd1);

    // R12: seal, then unlock attempts are ignored
    wr(4'h4, 32'hD928_C520);
    wr(4'h0, 32'h0000_2180);
    idle(5);
    rd(4'h0, v); chk(12, v, 32'h0000_2580);
    wr(4'h4, 32'hD928_C520);
    rd(4'h0, v); chk(12, v, 32'h0000_2580);
    wr(4'h8, 32'h99);
    idle(5);
    rd(4'h8, v); chk(12, v, 32'h30);

    done = 1;
    finish_run();
  end
endmodule